// File: doc/BRIEF.md
# Four-Register Two-Word Instruction Processor

This block is a small sequential processor with four general registers, a program counter and a single carry flag. It fetches instruction words over a synchronous memory port. Memory reads, memory writes and jumps need an address, and they take it from the word that follows the instruction. Register-to-register moves, complements, additions and subtractions fit in one word.

A two-bit operation class and a one-bit modifier together select one of eight operations. The program counter therefore steps by one or by two, depending on whether the instruction carries an address word. The processor has no interrupts, no pipeline and no cache. A program stops itself with a jump to its own address, which holds the program counter still.

Top module: `pairword_cpu`

## Requirements
- R1: An instruction word has its operation class in bits [7:6], the modifier in bit 5, the destination selector A1 in bits [3:2] and the source selector A2 in bits [1:0]. Bit 4 is ignored. For classes 0 and 3, the address A is the word at PC+1.
- R2: Class 0 with modifier 0 loads R(A1) from memory word A and advances PC by 2.
- R3: Class 0 with modifier 1 writes R(A2) to memory word A, touches no other word, and advances PC by 2.
- R4: Class 1 copies R(A2) into R(A1) when the modifier is 0, and writes the bitwise complement of R(A2) when it is 1. PC advances by 1.
- R5: Class 2 sets R(A1) to R(A1)+R(A2) when the modifier is 0, and to R(A1)-R(A2) when it is 1, modulo 2^DW. PC advances by 1. For example, A1=3 and A2=2 add R2 into R3.
- R6: An addition sets C to its carry out. A subtraction sets C to 1 when no borrow occurs, that is when R(A1) >= R(A2) unsigned. Every other instruction leaves C unchanged.
- R7: Class 3 with modifier 0 loads PC with A.
- R8: Class 3 with modifier 1 loads PC with A when C=1, and otherwise advances PC by 2.
- R9: A synchronous active-low reset clears PC, C and all four registers. The first fetch after reset reads address 0.
- R10: A read returns data on mem_rdata one cycle after mem_rd_en. mem_rd_en and mem_wr_en are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | DW | Memory word address |
| mem_rd_en | output | 1 | Read request; data returns the next cycle |
| mem_wr_en | output | 1 | Write strobe for mem_wdata at mem_addr |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, one cycle after the request |
| pc_out | output | DW | Current program counter |
| flag_c | output | 1 | Carry / condition flag |

## Verification
The assertions assume that mem_rdata holds a known, registered value in every cycle after a read request, because they decode the operation class straight from that word. They also assume that reset is held low at time zero. The bench supplies memory through a model with one cycle of read latency, and it holds reset low while each program is loaded. It fills every unused word with a fixed marker value, so that a stray write or a wrong fetch shows up at the ports. Each program ends in a jump to its own address, so the program counter settles before the bench looks at it.

// File: rtl/pwc_pkg.sv
// Shared types and field helpers for the two-word instruction processor.
// Assumes the instruction sits in the low eight bits of a memory word.
package pwc_pkg;
    localparam int NUM_REGS = 4;
    localparam int SEL_W    = $clog2(NUM_REGS);
    localparam int INSTR_W  = 8;

    typedef enum logic [1:0] {
        OPC_MEM   = 2'd0,
        OPC_MOVE  = 2'd1,
        OPC_ARITH = 2'd2,
        OPC_JUMP  = 2'd3
    } opc_t;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_ADDR  = 2'd2,
        ST_LOAD  = 2'd3
    } seq_t;

    function automatic opc_t field_opc(input logic [INSTR_W-1:0] w);
        return opc_t'(w[7:6]);
    endfunction

    function automatic logic field_mod(input logic [INSTR_W-1:0] w);
        return w[5];
    endfunction

    function automatic logic [SEL_W-1:0] field_dst(input logic [INSTR_W-1:0] w);
        return w[3:2];
    endfunction

    function automatic logic [SEL_W-1:0] field_src(input logic [INSTR_W-1:0] w);
        return w[1:0];
    endfunction
endpackage

// File: rtl/pwc_regfile.sv
// Four-entry register bank with one write port and two read ports.
// Assumes a synchronous active-low reset; reads are combinational.
module pwc_regfile
    import pwc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  logic [DW-1:0]    wdata,
    input  logic [SEL_W-1:0] rsel_a,
    input  logic [SEL_W-1:0] rsel_b,
    output logic [DW-1:0]    rdata_a,
    output logic [DW-1:0]    rdata_b
);
    logic [NUM_REGS-1:0][DW-1:0] bank;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DW-1:0] q;
        // Hold one register; clear on reset, load when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && (wsel == SEL_W'(g))) begin
                q <= wdata;
            end
        end
        assign bank[g] = q;
    end

    assign rdata_a = bank[rsel_a];
    assign rdata_b = bank[rsel_b];
endmodule

// File: rtl/pwc_alu.sv
// Combinational data unit for the move/complement and add/subtract classes.
// Assumes a = R(A1) and b = R(A2); carry is the no-borrow flag on subtraction.
module pwc_alu
    import pwc_pkg::*;
#(
    parameter int DW = 8
) (
    input  opc_t          opc,
    input  logic          modif,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] result,
    output logic          carry_out,
    output logic          carry_we
);
    localparam int SUM_W = DW + 1;
    logic [SUM_W-1:0] sum;

    // Pick the operation from class and modifier.
    always_comb begin
        sum       = '0;
        result    = b;
        carry_out = 1'b0;
        case (opc)
            OPC_MOVE: begin
                result = modif ? ~b : b;
            end
            OPC_ARITH: begin
                if (modif) begin
                    sum = {1'b0, a} + {1'b0, ~b} + SUM_W'(1);
                end else begin
                    sum = {1'b0, a} + {1'b0, b};
                end
                result    = sum[DW-1:0];
                carry_out = sum[DW];
            end
            default: begin
                result = b;
            end
        endcase
    end

    assign carry_we = (opc == OPC_ARITH);
endmodule

// File: rtl/pwc_sequencer.sv
// Fetch/execute control: program counter, carry flag, instruction hold and
// memory port drive. Assumes memory returns read data one cycle after the
// request, and that an address word follows each class 0 and class 3 instruction.
module pwc_sequencer
    import pwc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    mem_rdata,
    input  logic [DW-1:0]    reg_a,
    input  logic [DW-1:0]    reg_b,
    input  logic [DW-1:0]    alu_result,
    input  logic             alu_carry,
    input  logic             alu_carry_we,
    output logic [DW-1:0]    mem_addr,
    output logic             mem_rd_en,
    output logic             mem_wr_en,
    output logic [DW-1:0]    mem_wdata,
    output logic [DW-1:0]    pc,
    output logic             flag_c,
    output logic             rf_we,
    output logic [SEL_W-1:0] rf_wsel,
    output logic [DW-1:0]    rf_wdata,
    output logic [SEL_W-1:0] rsel_a,
    output logic [SEL_W-1:0] rsel_b,
    output opc_t             cur_opc,
    output logic             cur_mod,
    output logic             in_exec,
    output logic             in_addr
);
    localparam logic [DW-1:0] STEP1 = DW'(1);
    localparam logic [DW-1:0] STEP2 = DW'(2);

    seq_t             state_q, state_d;
    logic [DW-1:0]    pc_q, pc_d;
    logic             c_q, c_d;
    opc_t             ir_opc_q, ir_opc_d;
    logic             ir_mod_q, ir_mod_d;
    logic [SEL_W-1:0] ir_dst_q, ir_dst_d;
    logic [SEL_W-1:0] ir_src_q, ir_src_d;
    logic [SEL_W-1:0] cur_dst, cur_src;
    logic [DW-1:0]    addr_word;

    // Decode straight from the bus in execute, from the held copy afterwards.
    always_comb begin
        if (state_q == ST_EXEC) begin
            cur_opc = field_opc(mem_rdata[INSTR_W-1:0]);
            cur_mod = field_mod(mem_rdata[INSTR_W-1:0]);
            cur_dst = field_dst(mem_rdata[INSTR_W-1:0]);
            cur_src = field_src(mem_rdata[INSTR_W-1:0]);
        end else begin
            cur_opc = ir_opc_q;
            cur_mod = ir_mod_q;
            cur_dst = ir_dst_q;
            cur_src = ir_src_q;
        end
    end

    assign addr_word = mem_rdata;
    assign rsel_a    = cur_dst;
    assign rsel_b    = cur_src;
    assign rf_wsel   = cur_dst;

    // Next-state, program counter, flag and memory port decisions.
    always_comb begin
        state_d   = state_q;
        pc_d      = pc_q;
        c_d       = c_q;
        ir_opc_d  = ir_opc_q;
        ir_mod_d  = ir_mod_q;
        ir_dst_d  = ir_dst_q;
        ir_src_d  = ir_src_q;
        mem_addr  = pc_q;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_wdata = reg_b;
        rf_we     = 1'b0;
        rf_wdata  = alu_result;
        case (state_q)
            ST_FETCH: begin
                mem_addr  = pc_q;
                mem_rd_en = 1'b1;
                state_d   = ST_EXEC;
            end
            ST_EXEC: begin
                ir_opc_d = cur_opc;
                ir_mod_d = cur_mod;
                ir_dst_d = cur_dst;
                ir_src_d = cur_src;
                if (cur_opc == OPC_MEM || cur_opc == OPC_JUMP) begin
                    mem_addr  = pc_q + STEP1;
                    mem_rd_en = 1'b1;
                    state_d   = ST_ADDR;
                end else begin
                    rf_we    = 1'b1;
                    rf_wdata = alu_result;
                    pc_d     = pc_q + STEP1;
                    if (alu_carry_we) begin
                        c_d = alu_carry;
                    end
                    state_d = ST_FETCH;
                end
            end
            ST_ADDR: begin
                mem_addr = addr_word;
                if (ir_opc_q == OPC_MEM) begin
                    if (!ir_mod_q) begin
                        mem_rd_en = 1'b1;
                        state_d   = ST_LOAD;
                    end else begin
                        mem_wr_en = 1'b1;
                        mem_wdata = reg_b;
                        pc_d      = pc_q + STEP2;
                        state_d   = ST_FETCH;
                    end
                end else begin
                    if (!ir_mod_q || c_q) begin
                        pc_d = addr_word;
                    end else begin
                        pc_d = pc_q + STEP2;
                    end
                    state_d = ST_FETCH;
                end
            end
            ST_LOAD: begin
                rf_we    = 1'b1;
                rf_wdata = mem_rdata;
                pc_d     = pc_q + STEP2;
                state_d  = ST_FETCH;
            end
            default: begin
                state_d = ST_FETCH;
            end
        endcase
    end

    // Register control state; reset restarts at address 0 with C clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_FETCH;
            pc_q     <= '0;
            c_q      <= 1'b0;
            ir_opc_q <= OPC_MEM;
            ir_mod_q <= 1'b0;
            ir_dst_q <= '0;
            ir_src_q <= '0;
        end else begin
            state_q  <= state_d;
            pc_q     <= pc_d;
            c_q      <= c_d;
            ir_opc_q <= ir_opc_d;
            ir_mod_q <= ir_mod_d;
            ir_dst_q <= ir_dst_d;
            ir_src_q <= ir_src_d;
        end
    end

    assign pc      = pc_q;
    assign flag_c  = c_q;
    assign in_exec = (state_q == ST_EXEC);
    assign in_addr = (state_q == ST_ADDR);
endmodule

// File: rtl/pairword_cpu.sv
// Top of the four-register processor: joins sequencer, register bank and
// data unit. Assumes DW >= 8 and a synchronous memory with one cycle of read latency.
module pairword_cpu
    import pwc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [DW-1:0] mem_addr,
    output logic          mem_rd_en,
    output logic          mem_wr_en,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] pc_out,
    output logic          flag_c
);
    logic [DW-1:0]    reg_a, reg_b, alu_result, rf_wdata;
    logic             alu_carry, alu_carry_we, rf_we;
    logic [SEL_W-1:0] rf_wsel, rsel_a, rsel_b;
    opc_t             cur_opc;
    logic             cur_mod;
    logic             in_exec, in_addr;

    pwc_sequencer #(.DW(DW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .mem_rdata    (mem_rdata),
        .reg_a        (reg_a),
        .reg_b        (reg_b),
        .alu_result   (alu_result),
        .alu_carry    (alu_carry),
        .alu_carry_we (alu_carry_we),
        .mem_addr     (mem_addr),
        .mem_rd_en    (mem_rd_en),
        .mem_wr_en    (mem_wr_en),
        .mem_wdata    (mem_wdata),
        .pc           (pc_out),
        .flag_c       (flag_c),
        .rf_we        (rf_we),
        .rf_wsel      (rf_wsel),
        .rf_wdata     (rf_wdata),
        .rsel_a       (rsel_a),
        .rsel_b       (rsel_b),
        .cur_opc      (cur_opc),
        .cur_mod      (cur_mod),
        .in_exec      (in_exec),
        .in_addr      (in_addr)
    );

    pwc_regfile #(.DW(DW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .wsel    (rf_wsel),
        .wdata   (rf_wdata),
        .rsel_a  (rsel_a),
        .rsel_b  (rsel_b),
        .rdata_a (reg_a),
        .rdata_b (reg_b)
    );

    pwc_alu #(.DW(DW)) u_alu (
        .opc       (cur_opc),
        .modif     (cur_mod),
        .a         (reg_a),
        .b         (reg_b),
        .result    (alu_result),
        .carry_out (alu_carry),
        .carry_we  (alu_carry_we)
    );
endmodule

// File: rtl/pwc_checker.sv
// Temporal checks on the processor's port behaviour, bound to the top.
// Assumes reset is low at time zero and memory read data is known after each request.
module pwc_checker
    import pwc_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd_en,
    input logic          mem_wr_en,
    input logic [DW-1:0] mem_rdata,
    input logic [DW-1:0] pc_out,
    input logic          flag_c,
    input logic          in_exec,
    input logic          in_addr,
    input opc_t          cur_opc,
    input logic          cur_mod
);
    a_r10_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (pc_out == '0 && !flag_c));

    // R5 as well: register classes step PC by one.
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && (mem_rdata[7:6] == 2'd1 || mem_rdata[7:6] == 2'd2))
        |=> (pc_out - $past(pc_out)) == DW'(1));

    a_r3_store_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> (pc_out - $past(pc_out)) == DW'(2));

    a_r6_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_exec && mem_rdata[7:6] == 2'd2) |=> $stable(flag_c));

    a_r8_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (in_addr && cur_opc == OPC_JUMP && cur_mod && !flag_c)
        |=> (pc_out - $past(pc_out)) == DW'(2));
endmodule

bind pairword_cpu pwc_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_rdata (mem_rdata),
    .pc_out    (pc_out),
    .flag_c    (flag_c),
    .in_exec   (in_exec),
    .in_addr   (in_addr),
    .cur_opc   (cur_opc),
    .cur_mod   (cur_mod)
);

// File: tb/pairword_cpu_tb_top.sv
// Directed bench: one task per scenario, memory model with one cycle of read latency.
module pairword_cpu_tb_top;
    localparam int DW = 8;
    localparam logic [7:0] MARK = 8'hEE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] mem_addr, mem_wdata, mem_rdata, pc_out;
    logic          mem_rd_en, mem_wr_en, flag_c;
    logic [7:0]    mem [256];
    int            checks = 0;
    int            failures = 0;
    bit            done = 1'b0;

    always #5 clk = ~clk;

    pairword_cpu #(.DW(DW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd_en (mem_rd_en),
        .mem_wr_en (mem_wr_en),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .pc_out    (pc_out),
        .flag_c    (flag_c)
    );

    // Memory model: registered read, write on strobe.
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
        if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    end

    function automatic logic [7:0] enc(input int op, input int b, input int a1, input int a2);
        return 8'((op << 6) | (b << 5) | (a1 << 2) | a2);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic start_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) mem[i] = MARK;
    endtask

    task automatic run(input int cycles);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (cycles) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic halt_at(input int a);
        mem[a] = enc(3, 0, 0, 0);
        mem[a + 1] = 8'(a);
    endtask

    task automatic t_reset();
        start_reset();
        for (int r = 0; r < 4; r++) begin
            mem[2 * r] = enc(0, 1, 0, r);
            mem[2 * r + 1] = 8'(8'h90 + r);
        end
        halt_at(8);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R9: state right after reset, before the first edge with reset released
        chk("R9 pc", pc_out, 8'h00);
        chk("R9 carry", {7'b0, flag_c}, 8'h00);
        chk("R9 fetch addr", mem_addr, 8'h00);
        chk("R10 fetch rd_en", {7'b0, mem_rd_en}, 8'h01);
        repeat (60) @(posedge clk);
        @(negedge clk);
        for (int r = 0; r < 4; r++) chk("R9 reg zero", mem[8'h90 + r], 8'h00);
    endtask

    task automatic t_load_store();
        start_reset();
        mem[0] = enc(0, 0, 1, 0); mem[1] = 8'h80;
        mem[2] = enc(0, 1, 0, 1); mem[3] = 8'h90;
        mem[4] = enc(0, 0, 2, 0); mem[5] = 8'h81;
        mem[6] = enc(0, 1, 0, 2); mem[7] = 8'h91;
        halt_at(8);
        mem[8'h80] = 8'h5A; mem[8'h81] = 8'hC3;
        run(60);
        chk("R2 load/R3 store r1", mem[8'h90], 8'h5A);
        chk("R2 load/R3 store r2", mem[8'h91], 8'hC3);
        chk("R3 neighbour untouched", mem[8'h92], MARK);
        chk("R2 pc halt", pc_out, 8'h08);
    endtask

    task automatic t_move_not();
        start_reset();
        mem[0] = enc(0, 0, 0, 0); mem[1] = 8'h80;
        mem[2] = enc(1, 0, 1, 0);
        mem[3] = enc(1, 1, 2, 0);
        mem[4] = enc(0, 1, 0, 1); mem[5] = 8'h90;
        mem[6] = enc(0, 1, 0, 2); mem[7] = 8'h91;
        halt_at(8);
        mem[8'h80] = 8'h3C;
        run(60);
        chk("R4 move", mem[8'h90], 8'h3C);
        chk("R4 complement", mem[8'h91], 8'hC3);
        chk("R4 pc step", pc_out, 8'h08);
    endtask

    task automatic t_add_r3r2();
        start_reset();
        mem[0] = enc(0, 0, 3, 0); mem[1] = 8'h80;
        mem[2] = enc(0, 0, 2, 0); mem[3] = 8'h81;
        mem[4] = enc(2, 0, 3, 2);
        mem[5] = enc(0, 1, 0, 3); mem[6] = 8'h90;
        halt_at(7);
        mem[8'h80] = 8'hF0; mem[8'h81] = 8'h25;
        run(60);
        chk("R5 add r3+r2", mem[8'h90], 8'h15);
        chk("R6 add carry out", {7'b0, flag_c}, 8'h01);
        chk("R5 pc", pc_out, 8'h07);
    endtask

    task automatic t_sub();
        start_reset();
        mem[0] = enc(0, 0, 0, 0); mem[1] = 8'h80;
        mem[2] = enc(0, 0, 1, 0); mem[3] = 8'h81;
        mem[4] = enc(2, 1, 0, 1);
        mem[5] = enc(0, 1, 0, 0); mem[6] = 8'h90;
        mem[7] = enc(2, 1, 1, 0);
        mem[8] = enc(0, 1, 0, 1); mem[9] = 8'h91;
        halt_at(10);
        mem[8'h80] = 8'h30; mem[8'h81] = 8'h10;
        run(80);
        chk("R5 sub no borrow", mem[8'h90], 8'h20);
        chk("R5 sub wrap", mem[8'h91], 8'hF0);
        chk("R6 borrow clears C", {7'b0, flag_c}, 8'h00);
    endtask

    task automatic t_carry_hold();
        start_reset();
        mem[0] = enc(0, 0, 0, 0); mem[1] = 8'h80;
        mem[2] = enc(0, 0, 1, 0); mem[3] = 8'h81;
        mem[4] = enc(2, 0, 0, 1);
        mem[5] = enc(1, 1, 2, 0);
        mem[6] = enc(1, 0, 3, 1);
        mem[7] = enc(0, 1, 0, 0); mem[8] = 8'h90;
        mem[9] = enc(0, 0, 2, 0); mem[10] = 8'h82;
        halt_at(11);
        mem[8'h80] = 8'hFF; mem[8'h81] = 8'h01; mem[8'h82] = 8'h00;
        run(80);
        chk("R5 add wrap to zero", mem[8'h90], 8'h00);
        chk("R6 C held across non-arith", {7'b0, flag_c}, 8'h01);
    endtask

    task automatic t_jump();
        start_reset();
        mem[0] = enc(3, 0, 0, 0); mem[1] = 8'h10;
        mem[2] = enc(0, 1, 0, 0); mem[3] = 8'h90;
        halt_at(16);
        run(40);
        chk("R7 jump skips store", mem[8'h90], MARK);
        chk("R7 pc at target", pc_out, 8'h10);
    endtask

    task automatic t_jc();
        start_reset();
        mem[0] = enc(3, 1, 0, 0); mem[1] = 8'h20;
        mem[2] = enc(0, 0, 0, 0); mem[3] = 8'h80;
        mem[4] = enc(0, 0, 1, 0); mem[5] = 8'h81;
        mem[6] = enc(2, 0, 0, 1);
        mem[7] = enc(3, 1, 0, 0); mem[8] = 8'h20;
        mem[9] = enc(0, 1, 0, 1); mem[10] = 8'h91;
        mem[32] = enc(0, 1, 0, 1); mem[33] = 8'h90;
        halt_at(34);
        mem[8'h80] = 8'hFF; mem[8'h81] = 8'h01;
        run(80);
        chk("R8 not taken then taken", mem[8'h90], 8'h01);
        chk("R8 taken skips fallthrough", mem[8'h91], MARK);
        chk("R8 pc", pc_out, 8'h22);
    endtask

    task automatic t_spare_bit();
        // R1: bit 4 set in a move must not change its meaning
        start_reset();
        mem[0] = enc(0, 0, 0, 0); mem[1] = 8'h80;
        mem[2] = enc(1, 0, 1, 0) | 8'h10;
        mem[3] = enc(0, 1, 0, 1); mem[4] = 8'h90;
        halt_at(5);
        mem[8'h80] = 8'h69;
        run(50);
        chk("R1 spare bit ignored", mem[8'h90], 8'h69);
    endtask

    initial begin
        t_reset();
        t_load_store();
        t_move_not();
        t_add_r3r2();
        t_sub();
        t_carry_hold();
        t_jump();
        t_jc();
        t_spare_bit();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule